// File: doc/BRIEF.md
# Programmable Address Window Decoder with Target Routing

The block decodes physical addresses against sixteen programmable windows and reports which target the access belongs to. Software sets each window up through a small 32-bit register bus. Every window has four registers: control (an enable bit and a 4-bit target), security (four qualifier bits), a low bound and a high bound. The bounds are kept in units of 1 MB blocks.

On every lookup cycle the decoder takes a 64-bit address, a secure flag and a read/write flag. One cycle later it returns a hit flag, the routed target and a security-violation flag. Window 0 is reserved for configuration space. It cannot be switched off and always spans sixteen 1 MB blocks from its low bound, so software can move it but cannot resize it. The remaining windows cover an inclusive block range. If windows overlap, the lowest-numbered window decides the result.

Register-group address = window index × 0x20 + offset. The offsets are: control 0x0, security 0x4, low bound 0x8, high bound 0xC. Bits 1:0 of the register address are ignored. Offsets 0x10 to 0x1C in a group read as zero and ignore writes.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset, window 0 control reads 0x1 and every other control, security and bound register reads 0. A lookup then hits window 0 (target 0) for blocks 0 to 15 only.
- R2: The control register keeps bit 0 (enable) and bits 11:8 (target). The security register keeps bits 3:0. The bound registers keep bits 31:4. All other bits read as 0.
- R3: Window 0 control bit 0 always reads 1, whatever value is written to it. Its target field stays writable.
- R4: For windows 1 to 15, an address hits when the window is enabled, address bits 63:48 are zero, and low ≤ addr[47:20] ≤ high. Both ends are inclusive. A disabled window never hits.
- R5: Window 0 hits when addr[47:20] lies in [low, low+15] and addr[63:48] is zero. Its high-bound register is stored but has no effect on decoding.
- R6: When several windows match, the lowest-numbered one supplies the target.
- R7: A lookup that matches no window returns hit=0, target=0 and violation=0.
- R8: The chosen window's security bit 2 qualifies writes and bit 3 qualifies reads. A non-secure access to a window whose bit for that direction is set returns violation=1, hit=0 and target=0. A secure access is never flagged.
- R9: Security bit 0 of a window blocks non-secure register writes to that window's group, which then have no effect. Bit 1 makes non-secure reads of that group return 0. Secure register accesses are never blocked.
- R10: Results are registered. A lookup presented in cycle t shows up with res_valid=1 in cycle t+1. In any cycle without a lookup the next res_valid, res_hit and res_violation are 0.
- R11: A register write in cycle t is used by a lookup presented in cycle t+1. This includes moving window 0's low bound.
- R12: A register read presented in cycle t returns its data on reg_rdata in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_secure | input | 1 | Register access is secure |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd_en |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Physical address to decode |
| lk_secure | input | 1 | Lookup is a secure access |
| lk_write | input | 1 | Lookup is a write (else a read) |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Address hit a permitted window |
| res_target | output | 4 | Target of the winning window |
| res_violation | output | 1 | Non-secure access hit a protected window |

## Verification
The properties assume that reset is held for at least one clock and that lk_valid is low while reset is asserted. They also assume that a register read of window 0's control is issued as a secure access whenever its read-protection bit might be set. The bench holds lookups low during reset. It reads window 0's control only with secure reads. It drives every request on the falling edge for exactly one cycle, so each registered result can be matched to the one request that produced it.

// File: rtl/awd_pkg.sv
package awd_pkg;
    // Lowest and highest physical address bits that form a 1 MB block number
    localparam int BLK_LSB = 20;
    localparam int BLK_MSB = 47;
    localparam int BLK_W   = BLK_MSB - BLK_LSB + 1;
    localparam int REG_W   = 32;
    localparam int TGT_W   = 4;
    localparam int SEC_W   = 4;

    // Security qualifier bit positions
    localparam int SEC_CTRL_WR = 0;
    localparam int SEC_CTRL_RD = 1;
    localparam int SEC_DATA_WR = 2;
    localparam int SEC_DATA_RD = 3;

    // Register selectors inside a window group (reg_addr[4:2])
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_SEC  = 3'd1;
    localparam logic [2:0] SEL_LO   = 3'd2;
    localparam logic [2:0] SEL_HI   = 3'd3;

    typedef struct packed {
        logic             en;
        logic [TGT_W-1:0] tgt;
        logic [SEC_W-1:0] sec;
        logic [BLK_W-1:0] lo;
        logic [BLK_W-1:0] hi;
    } win_cfg_t;
endpackage

// File: rtl/awd_window_match.sv
// awd_window_match: compares one block number against one window.
// Assumes: the caller supplies the block number already cut from the
// address and a flag saying the address lies inside the decoded range.
// FIXED=1 gives a base-relative span of FIXED_BLOCKS blocks and ignores
// both the high bound and the enable bit.
module awd_window_match
    import awd_pkg::*;
#(
    parameter bit FIXED        = 1'b0,
    parameter int FIXED_BLOCKS = 16
) (
    input  win_cfg_t         cfg,
    input  logic [BLK_W-1:0] blk,
    input  logic             in_range,
    output logic             hit
);
    localparam int SUM_W = BLK_W + 1;

    generate
        if (FIXED) begin : g_fixed
            logic [SUM_W-1:0] last_blk;
            logic             unused_cfg;
            // Inclusive last block of the fixed-span window
            always_comb last_blk = {1'b0, cfg.lo} + SUM_W'(FIXED_BLOCKS - 1);
            // Span test from the movable base
            always_comb hit = in_range && (blk >= cfg.lo) &&
                              ({1'b0, blk} <= last_blk);
            always_comb unused_cfg = ^{cfg.hi, cfg.en, cfg.tgt, cfg.sec};
        end else begin : g_range
            logic unused_cfg;
            // Inclusive low/high bound test on an enabled window
            always_comb hit = in_range && cfg.en &&
                              (blk >= cfg.lo) && (blk <= cfg.hi);
            always_comb unused_cfg = ^{cfg.tgt, cfg.sec};
        end
    endgenerate
endmodule

// File: rtl/awd_regfile.sv
// awd_regfile: window configuration storage behind the register bus.
// Assumes: one access per cycle per strobe. A read issued in the same
// cycle as a write returns the value held before that write.
// Window 0's enable bit is held at 1 on every write.
module awd_regfile
    import awd_pkg::*;
#(
    parameter  int NUM_WIN = 16,
    localparam int IDX_W   = $clog2(NUM_WIN),
    localparam int RA_W    = IDX_W + 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic                   secure,
    input  logic [RA_W-1:0]        addr,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output win_cfg_t [NUM_WIN-1:0] cfg
);
    win_cfg_t [NUM_WIN-1:0] cfg_q;
    logic [IDX_W-1:0]       widx;
    logic [2:0]             sel;
    logic                   idx_ok;
    logic                   wr_ok;
    logic                   rd_ok;
    logic [REG_W-1:0]       rd_mux;
    logic                   unused_bits;

    // Split the byte address into window index and register selector
    always_comb begin
        widx = addr[RA_W-1:5];
        sel  = addr[4:2];
    end

    always_comb unused_bits = ^{addr[1:0], wdata[31:12], wdata[7:4]};

    // Access permission for the addressed group
    always_comb begin
        idx_ok = (int'(widx) < NUM_WIN);
        wr_ok  = idx_ok && (secure || !cfg_q[widx].sec[SEC_CTRL_WR]);
        rd_ok  = idx_ok && (secure || !cfg_q[widx].sec[SEC_CTRL_RD]);
    end

    // Configuration write and reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                cfg_q[i] <= '0;
            end
            cfg_q[0].en <= 1'b1;
        end else if (wr_en && wr_ok) begin
            case (sel)
                SEL_CTRL: begin
                    cfg_q[widx].en  <= wdata[0] | (widx == '0);
                    cfg_q[widx].tgt <= wdata[11:8];
                end
                SEL_SEC: cfg_q[widx].sec <= wdata[SEC_W-1:0];
                SEL_LO:  cfg_q[widx].lo  <= wdata[31:4];
                SEL_HI:  cfg_q[widx].hi  <= wdata[31:4];
                default: ;
            endcase
        end
    end

    // Read data selection for the addressed register
    always_comb begin
        rd_mux = '0;
        if (rd_ok) begin
            case (sel)
                SEL_CTRL: rd_mux = {20'b0, cfg_q[widx].tgt, 7'b0, cfg_q[widx].en};
                SEL_SEC:  rd_mux = {28'b0, cfg_q[widx].sec};
                SEL_LO:   rd_mux = {cfg_q[widx].lo, 4'b0};
                SEL_HI:   rd_mux = {cfg_q[widx].hi, 4'b0};
                default:  rd_mux = '0;
            endcase
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    always_comb cfg = cfg_q;
endmodule

// File: rtl/awd_select.sv
// awd_select: priority pick among window matches, security check and
// result register.
// Assumes: hits[i] is already qualified by enable and range, and the
// lowest index takes priority.
module awd_select
    import awd_pkg::*;
#(
    parameter  int NUM_WIN = 16,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WIN-1:0]     hits,
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic                   lk_valid,
    input  logic                   lk_secure,
    input  logic                   lk_write,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [TGT_W-1:0]       res_target,
    output logic                   res_violation
);
    logic             found;
    logic [IDX_W-1:0] win;
    logic             guarded;
    logic             deny;
    logic             grant;

    // Lowest-numbered matching window
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                win   = IDX_W'(i);
            end
        end
    end

    // Direction-specific security qualifier of the winner
    always_comb begin
        guarded = lk_write ? cfg[win].sec[SEC_DATA_WR] : cfg[win].sec[SEC_DATA_RD];
        deny    = lk_valid && found && !lk_secure && guarded;
        grant   = lk_valid && found && !deny;
    end

    // One-cycle registered decode result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_hit       <= 1'b0;
            res_target    <= '0;
            res_violation <= 1'b0;
        end else begin
            res_valid     <= lk_valid;
            res_hit       <= grant;
            res_target    <= grant ? cfg[win].tgt : '0;
            res_violation <= deny;
        end
    end
endmodule

// File: rtl/addr_win_decoder.sv
// addr_win_decoder: sixteen-window address decoder with target routing
// and per-window security qualifiers.
// Assumes: the register bus and lookup port share the clock. Window 0
// is the fixed-span configuration window.
module addr_win_decoder
    import awd_pkg::*;
#(
    parameter  int NUM_WIN   = 16,
    parameter  int W0_BLOCKS = 16,
    localparam int RA_W      = $clog2(NUM_WIN) + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic             reg_secure,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             lk_valid,
    input  logic [63:0]      lk_addr,
    input  logic             lk_secure,
    input  logic             lk_write,
    output logic             res_valid,
    output logic             res_hit,
    output logic [3:0]       res_target,
    output logic             res_violation
);
    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hits;
    logic [BLK_W-1:0]       blk;
    logic                   in_range;
    logic                   unused_low;

    // Block number and decoded-range qualifier of the lookup address
    always_comb begin
        blk      = lk_addr[BLK_MSB:BLK_LSB];
        in_range = (lk_addr[63:BLK_MSB+1] == '0);
    end

    always_comb unused_low = ^lk_addr[BLK_LSB-1:0];

    awd_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .rd_en  (reg_rd_en),
        .secure (reg_secure),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .cfg    (cfg)
    );

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            awd_window_match #(
                .FIXED        (w == 0),
                .FIXED_BLOCKS (W0_BLOCKS)
            ) u_match (
                .cfg      (cfg[w]),
                .blk      (blk),
                .in_range (in_range),
                .hit      (hits[w])
            );
        end
    endgenerate

    awd_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .hits          (hits),
        .cfg           (cfg),
        .lk_valid      (lk_valid),
        .lk_secure     (lk_secure),
        .lk_write      (lk_write),
        .res_valid     (res_valid),
        .res_hit       (res_hit),
        .res_target    (res_target),
        .res_violation (res_violation)
    );
endmodule

// File: rtl/awd_checker.sv
// awd_checker: temporal properties on the decoder's ports.
module awd_checker #(
    parameter int RA_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_rd_en,
    input logic            reg_secure,
    input logic [RA_W-1:0] reg_addr,
    input logic [31:0]     reg_rdata,
    input logic            lk_valid,
    input logic            res_valid,
    input logic            res_hit,
    input logic [3:0]      res_target,
    input logic            res_violation
);
    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && !res_violation));

    // R8
    hit_xor_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_hit && res_violation));

    // R7
    miss_target_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_target == 4'd0));

    // R3
    w0_enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_secure && reg_addr == '0) |=> reg_rdata[0]);
endmodule

bind addr_win_decoder awd_checker #(.RA_W(RA_W)) u_awd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rd_en     (reg_rd_en),
    .reg_secure    (reg_secure),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .lk_valid      (lk_valid),
    .res_valid     (res_valid),
    .res_hit       (res_hit),
    .res_target    (res_target),
    .res_violation (res_violation)
);

// File: tb/tb_addr_win_decoder.sv
module tb_addr_win_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0, reg_secure = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0, lk_secure = 1'b0, lk_write = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        res_valid, res_hit, res_violation;
    logic [3:0]  res_target;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Bench model of the programmed state
    logic        m_en [NW];
    logic [3:0]  m_tgt[NW];
    logic [3:0]  m_sec[NW];
    logic [27:0] m_lo [NW];
    logic [27:0] m_hi [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_win_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_secure(reg_secure),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_secure(lk_secure),
        .lk_write(lk_write), .res_valid(res_valid), .res_hit(res_hit),
        .res_target(res_target), .res_violation(res_violation)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] ra(input int w, input int off);
        return 9'(w * 32 + off);
    endfunction

    task automatic model_reset();
        for (int w = 0; w < NW; w++) begin
            m_en[w] = (w == 0); m_tgt[w] = 0; m_sec[w] = 0; m_lo[w] = 0; m_hi[w] = 0;
        end
    endtask

    task automatic reg_wr(input int w, input int off, input logic [31:0] d, input logic sec);
        @(negedge clk);
        reg_wr_en = 1; reg_secure = sec; reg_addr = ra(w, off); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
        if (sec || !m_sec[w][0]) begin
            case (off)
                0: begin m_en[w] = d[0] | (w == 0); m_tgt[w] = d[11:8]; end
                4: m_sec[w] = d[3:0];
                8: m_lo[w] = d[31:4];
                12: m_hi[w] = d[31:4];
                default: ;
            endcase
        end
    endtask

    task automatic reg_rd(input int w, input int off, input logic sec, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1; reg_secure = sec; reg_addr = ra(w, off);
        @(negedge clk);
        reg_rd_en = 0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_reg(input int w, input int off, input logic sec);
        if (!sec && m_sec[w][1]) return 0;
        case (off)
            0: return {20'b0, m_tgt[w], 7'b0, m_en[w]};
            4: return {28'b0, m_sec[w]};
            8: return {m_lo[w], 4'b0};
            12: return {m_hi[w], 4'b0};
            default: return 0;
        endcase
    endfunction

    // Expected {valid, hit, violation, target}
    function automatic logic [6:0] exp_look(input logic [63:0] a, input logic sec, input logic wr);
        logic [27:0] b; bit found; int idx; logic prot;
        b = a[47:20]; found = 0; idx = 0;
        if (a[63:48] == 0) begin
            for (int w = 0; w < NW; w++) begin
                if (!found) begin
                    if (w == 0) begin
                        if (b >= m_lo[0] && {1'b0, b} <= {1'b0, m_lo[0]} + 29'd15) begin found = 1; idx = 0; end
                    end else if (m_en[w] && b >= m_lo[w] && b <= m_hi[w]) begin
                        found = 1; idx = w;
                    end
                end
            end
        end
        if (!found) return 7'b100_0000;
        prot = wr ? m_sec[idx][2] : m_sec[idx][3];
        if (!sec && prot) return 7'b101_0000;
        return {3'b110, m_tgt[idx]};
    endfunction

    task automatic look(input string req, input logic [63:0] a, input logic sec, input logic wr);
        logic [6:0] e;
        @(negedge clk);
        lk_valid = 1; lk_addr = a; lk_secure = sec; lk_write = wr;
        @(negedge clk);
        lk_valid = 0;
        e = exp_look(a, sec, wr);
        chk(req, {25'b0, res_valid, res_hit, res_violation, res_target}, {25'b0, e});
    endtask

    function automatic logic [63:0] blk_addr(input logic [27:0] b);
        return {16'b0, b, 20'($urandom)};
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset contents
        for (int w = 0; w < 4; w++)
            for (int off = 0; off < 16; off += 4) begin
                reg_rd(w, off, 1'b1, d); chk("R1 reset reg", d, exp_reg(w, off, 1'b1));
            end
        look("R1 w0 block 0", blk_addr(28'd0), 0, 0);
        look("R1 w0 block 15", blk_addr(28'd15), 0, 1);
        look("R7 miss block 16", blk_addr(28'd16), 1, 0);

        // R12 + R2 + R3: window 0 control write cannot clear enable
        reg_wr(0, 0, 32'hFFFF_F5F0, 1);
        reg_rd(0, 0, 1, d); chk("R3 w0 enable held", d, 32'h0000_0501);
        reg_wr(1, 0, 32'hFFFF_FFFF, 1);
        reg_rd(1, 0, 1, d); chk("R2 ctrl mask", d, 32'h0000_0F01);
        reg_wr(1, 4, 32'hFFFF_FFF0, 1);
        reg_rd(1, 4, 1, d); chk("R2 sec mask", d, 32'h0);
        reg_wr(1, 8, 32'hFFFF_FFFF, 1);
        reg_rd(1, 8, 1, d); chk("R2 lo mask", d, 32'hFFFF_FFF0);
        reg_wr(1, 0, 32'h0, 1);
        reg_wr(1, 8, 32'h0, 1);
        reg_wr(1, 16, 32'hFFFF_FFFF, 1);
        reg_rd(1, 16, 1, d); chk("R2 hole reads zero", d, 32'h0);

        // R11 + R5: move window 0 and decode on the very next lookup
        reg_wr(0, 8, 32'h0000_1000, 1);
        look("R11 new base used at once", blk_addr(28'h100), 0, 0);
        look("R5 old base gone", blk_addr(28'h0), 0, 0);
        reg_wr(0, 12, 32'h0000_8000, 1);
        look("R5 w0 last block", blk_addr(28'h10F), 0, 0);
        look("R5 w0 hi ignored", blk_addr(28'h110), 0, 0);
        look("R5 w0 below base", blk_addr(28'h0FF), 0, 0);

        // R4 + R6: adjacent and overlapping windows
        reg_wr(1, 8, 32'h0000_2000, 1); reg_wr(1, 12, 32'h0000_20F0, 1); reg_wr(1, 0, 32'h101, 1);
        reg_wr(2, 8, 32'h0000_2100, 1); reg_wr(2, 12, 32'h0000_21F0, 1); reg_wr(2, 0, 32'h201, 1);
        reg_wr(3, 8, 32'h0000_2080, 1); reg_wr(3, 12, 32'h0000_3000, 1); reg_wr(3, 0, 32'h301, 1);
        reg_wr(4, 8, 32'h0000_1050, 1); reg_wr(4, 12, 32'h0000_1200, 1); reg_wr(4, 0, 32'h401, 1);
        reg_wr(5, 8, 32'h0000_4000, 1); reg_wr(5, 12, 32'h0000_4100, 1); reg_wr(5, 0, 32'h500, 1);
        look("R6 w1 beats w3", blk_addr(28'h208), 1, 0);
        look("R6 w2 beats w3", blk_addr(28'h215), 1, 1);
        look("R6 w0 beats w4", blk_addr(28'h105), 1, 0);
        look("R4 w3 above w2", blk_addr(28'h220), 1, 0);
        look("R4 w3 inclusive top", blk_addr(28'h300), 1, 0);
        look("R4 disabled w5", blk_addr(28'h405), 1, 0);
        look("R4 upper bits set", {16'h0001, 28'h208, 20'h0}, 1, 0);
        for (int w = 1; w < 5; w++) begin
            look("R4 lo-1", blk_addr(m_lo[w] - 1), 1, 0);
            look("R4 lo", blk_addr(m_lo[w]), 1, 0);
            look("R4 hi", blk_addr(m_hi[w]), 1, 0);
            look("R4 hi+1", blk_addr(m_hi[w] + 1), 1, 0);
        end

        // R8: data-path security qualifiers
        reg_wr(2, 4, 32'h8, 1);
        look("R8 nonsec read blocked", blk_addr(28'h210), 0, 0);
        look("R8 nonsec write allowed", blk_addr(28'h210), 0, 1);
        look("R8 secure read allowed", blk_addr(28'h210), 1, 0);
        reg_wr(2, 4, 32'h4, 1);
        look("R8 nonsec write blocked", blk_addr(28'h21F), 0, 1);

        // R9: register-bus protection
        reg_wr(4, 4, 32'h3, 1);
        reg_wr(4, 0, 32'hE01, 0);
        reg_rd(4, 0, 1, d); chk("R9 nonsec write dropped", d, 32'h0000_0401);
        reg_rd(4, 8, 0, d); chk("R9 nonsec read zero", d, 32'h0);
        reg_rd(4, 8, 1, d); chk("R9 secure read", d, 32'h0000_1050);
        reg_wr(4, 4, 32'h0, 1);
        reg_wr(4, 0, 32'hE01, 0);
        reg_rd(4, 0, 0, d); chk("R9 unprotected nonsec write", d, 32'h0000_0E01);

        // R10: idle cycle leaves result quiet
        @(negedge clk);
        chk("R10 idle", {29'b0, res_valid, res_hit, res_violation}, 32'h0);

        // Random reprogramming and boundary lookups (R4 R6 R8)
        for (int it = 0; it < 300; it++) begin
            int w;
            logic [27:0] lo, b;
            w = 1 + int'($urandom_range(14));
            lo = 28'($urandom_range(1023));
            reg_wr(w, 8, {lo, 4'b0}, 1);
            reg_wr(w, 12, {lo + 28'($urandom_range(80)) - 28'd8, 4'b0}, 1);
            reg_wr(w, 0, {20'b0, 4'($urandom), 7'b0, 1'($urandom)}, 1);
            reg_wr(w, 4, 32'($urandom_range(15)), 1);
            for (int k = 0; k < 4; k++) begin
                int v;
                v = 1 + int'($urandom_range(14));
                case ($urandom_range(4))
                    0: b = m_lo[v] - 1;
                    1: b = m_lo[v];
                    2: b = m_hi[v];
                    3: b = m_hi[v] + 1;
                    default: b = 28'($urandom_range(1200));
                endcase
                look("R6 random decode", blk_addr(b), 1'($urandom), 1'($urandom));
            end
        end

        // R1: reset again restores defaults
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        model_reset();
        reg_rd(0, 0, 1, d); chk("R1 w0 ctrl after reset", d, 32'h1);
        reg_rd(3, 0, 1, d); chk("R1 w3 ctrl after reset", d, 32'h0);
        look("R1 base back at 0", blk_addr(28'h3), 0, 0);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule